// File: doc/BRIEF.md
# Aggregated Interrupt Cause Register Unit

This block collects per-bit event pulses into three 32-bit cause banks (transmit, receive and miscellaneous) and folds them into one interrupt line for a host processor. Each bank keeps a cause register, a mask, and a per-bit choice of how a bit is cleared: either by reading it or by writing a one to it. Software can also set cause bits directly, which lets it raise an interrupt on purpose.

A bank counts as active while any of its cause bits is set and unmasked. Each active bank sets its own bit in a three-bit summary register: bit 0 for transmit, bit 1 for receive and bit 2 for miscellaneous. Reading the summary register clears it. The summary has its own mask. A registered interrupt output is high while any summary bit is set and not masked.

The host reaches every register through one 32-bit word port. `addr_i[5:3]` picks the block: 0 is transmit, 1 is receive, 2 is miscellaneous and 3 is the summary. `addr_i[2:0]` picks the register inside that block. The bank offsets are:
- 0: raw cause. A read returns it; a write clears bits written as one.
- 1: masked cause view (read only).
- 2: software set.
- 3: mask value (read only).
- 4: mask-set strobe.
- 5: mask-clear strobe.
- 6: clear mode.

In the summary block, offset 0 is the summary cause and offset 1 is the summary mask. Any other offset reads as zero. `rdata_o` is combinational and valid in the cycle in which `rd_en_i` is high. Read side effects take place at the clock edge that ends that cycle.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the following hold:
  - all cause bits and summary bits are 0;
  - every bank mask reads all ones (0xFFFFFFFF);
  - every clear-mode register reads 0;
  - the summary mask reads 0x7;
  - `irq_o` is low.
- R2: A one-cycle pulse on a bit of `ev_tx_i`, `ev_rx_i` or `ev_misc_i` sets that cause bit at the next edge. The bit stays set until it is cleared. A read of a bit in write-one-to-clear mode leaves the bit set.
- R3: Writing offset 2 with a one in a bit position sets that cause bit.
- R4: The following apply to the mask registers:
  - A write to offset 4 sets every mask bit written as one.
  - A write to offset 5 clears every mask bit written as one and leaves all other mask bits unchanged.
  - Offset 3 returns the current mask.
  - Writing all ones to offset 4 masks the whole bank.
- R5: The clear-mode register works as follows:
  - A clear-mode bit of 1 selects clear-on-read for that cause bit, and 0 selects write-one-to-clear.
  - A write to offset 0 clears exactly the ones written, but only on bits in write-one-to-clear mode.
  - Bits in clear-on-read mode ignore such writes.
- R6: Reads of offset 0 and offset 1 behave as follows:
  - A read of offset 0 returns the raw cause and clears every returned bit that is in clear-on-read mode.
  - A read of offset 1 returns cause AND NOT mask, and clears only the returned bits that are in clear-on-read mode.
- R7: If an event pulse and a clear (a write-one-to-clear write or a clear-on-read read) hit the same bit in the same cycle, the bit stays set.
- R8: The summary register behaves as follows:
  - A bank that has any unmasked cause bit set sets its summary bit (transmit bit 0, receive bit 1, miscellaneous bit 2) one edge later.
  - The summary bit stays set until the summary register is read at block 3, offset 0.
  - That read clears the summary bits of banks that are no longer active.
- R9: The interrupt output and summary mask behave as follows:
  - `irq_o` is registered. It rises one edge after a summary bit is set while its summary-mask bit is 0.
  - A summary-mask write of 0xFFFFFFFF blocks everything.
  - A write of 0xFFFFFFF8 enables all three banks.
  - An event therefore shows on `irq_o` two edges after the edge that captures it.
- R10: The hand-shake bit of the miscellaneous bank (bit 27 by default) can be masked or unmasked alone by writing only that bit to offset 4 or offset 5. All other mask bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tx_i | input | 32 | Transmit event pulses, one per cause bit |
| ev_rx_i | input | 32 | Receive event pulses, one per cause bit |
| ev_misc_i | input | 32 | Miscellaneous event pulses, one per cause bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers read side effects) |
| addr_i | input | 6 | Word address: block in [5:3], offset in [2:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The clearing logic is tried with the same cause pattern under clear modes of all zeros, all ones and a mix. These runs show whether a read clears only clear-on-read bits and a write clears only write-one-to-clear bits.

Masked-view reads use a partial mask with set bits on both sides of it. This shows whether the view applies the mask and whether its clearing is limited to the returned bits.

Collision cases drive an event into a bit in the same cycle as a write clear or a read clear. Interrupt timing is sampled on each edge after an event, so a missing or extra pipeline register shows up.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg: shared register offsets and bank indices for the
// aggregated interrupt cause unit. Assumes word addressing with a 3-bit
// offset field below the block index.
package irqc_pkg;

    localparam int NBANK     = 3;
    localparam int OFF_W     = 3;

    localparam int BANK_TX   = 0;
    localparam int BANK_RX   = 1;
    localparam int BANK_MISC = 2;
    localparam int SUM_BLK   = 3;

    typedef enum logic [OFF_W-1:0] {
        OFF_RAW  = 3'd0,
        OFF_MSKD = 3'd1,
        OFF_SET  = 3'd2,
        OFF_MASK = 3'd3,
        OFF_MSET = 3'd4,
        OFF_MCLR = 3'd5,
        OFF_MODE = 3'd6
    } bank_off_e;

    localparam logic [OFF_W-1:0] SUM_OFF_CAUSE = 3'd0;
    localparam logic [OFF_W-1:0] SUM_OFF_MASK  = 3'd1;

endpackage

// File: rtl/irqc_bank.sv
// Module irqc_bank: one cause bank with a cause register, a mask, and a
// per-bit clear mode (1 = clear on read, 0 = write one to clear).
// Assumes reads and writes never target the bank in the same cycle.
// Event pulses take priority over any clear of the same bit.
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    ev_i,
    input  logic             sel_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [DW-1:0]    mask_o,
    output logic             active_o
);

    logic [DW-1:0] cause_q, mask_q, mode_q;
    logic [DW-1:0] cause_clr, sw_set;
    logic          wr_raw, wr_set, wr_mset, wr_mclr, wr_mode, rd_raw, rd_mskd;

    // Purpose: decode the host strobes that target this bank.
    always_comb begin
        wr_raw  = sel_i && wr_en_i && (off_i == OFF_RAW);
        wr_set  = sel_i && wr_en_i && (off_i == OFF_SET);
        wr_mset = sel_i && wr_en_i && (off_i == OFF_MSET);
        wr_mclr = sel_i && wr_en_i && (off_i == OFF_MCLR);
        wr_mode = sel_i && wr_en_i && (off_i == OFF_MODE);
        rd_raw  = sel_i && rd_en_i && (off_i == OFF_RAW);
        rd_mskd = sel_i && rd_en_i && (off_i == OFF_MSKD);
    end

    // Purpose: gather the clear and software-set requests for each cause bit.
    always_comb begin
        cause_clr = '0;
        if (wr_raw)  cause_clr = cause_clr | (wdata_i & ~mode_q);
        if (rd_raw)  cause_clr = cause_clr | (cause_q & mode_q);
        if (rd_mskd) cause_clr = cause_clr | (cause_q & ~mask_q & mode_q);
        sw_set = wr_set ? wdata_i : '0;
    end

    // Purpose: update the cause register, letting events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~cause_clr) | sw_set | ev_i;
    end

    // Purpose: apply the mask-set and mask-clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mset) mask_q <= mask_q | wdata_i;
        else if (wr_mclr) mask_q <= mask_q & ~wdata_i;
    end

    // Purpose: hold the per-bit clear-mode selection.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= wdata_i;
    end

    // Purpose: select read data for this bank's offsets.
    always_comb begin
        case (off_i)
            OFF_RAW:  rdata_o = cause_q;
            OFF_MSKD: rdata_o = cause_q & ~mask_q;
            OFF_MASK: rdata_o = mask_q;
            OFF_MODE: rdata_o = mode_q;
            default:  rdata_o = '0;
        endcase
    end

    assign mask_o   = mask_q;
    assign active_o = |(cause_q & ~mask_q);

    p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((cause_q & $past(ev_i)) == $past(ev_i)));

    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_i & cause_clr) != '0) |=>
        ((cause_q & $past(ev_i & cause_clr)) == $past(ev_i & cause_clr)));

    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

    p_mask_clr_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> (((mask_q & $past(wdata_i)) == '0) &&
                     ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i)))));

    p_w1c_spares_cor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_raw && !rd_en_i) |=>
        ((cause_q & $past(mode_q & cause_q)) == $past(mode_q & cause_q)));

    p_cor_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_raw && !wr_en_i && (ev_i == '0)) |=> ((cause_q & $past(mode_q)) == '0));

endmodule

// File: rtl/irqc_summary.sv
// Module irqc_summary: summary cause register with one bit per bank and a
// software mask, plus the registered interrupt output. Assumes active_i is
// the per-bank OR of unmasked cause bits. A read of the cause offset clears
// the bits of banks that are no longer active.
module irqc_summary
    import irqc_pkg::*;
#(
    parameter int DW = 32,
    parameter int NB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    active_i,
    input  logic             sel_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [NB-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             irq_o
);

    logic [NB-1:0] sum_q, smask_q;
    logic          rd_sum, wr_mask;
    logic          irq_q;

    // Purpose: decode the summary-block strobes.
    always_comb begin
        rd_sum  = sel_i && rd_en_i && (off_i == SUM_OFF_CAUSE);
        wr_mask = sel_i && wr_en_i && (off_i == SUM_OFF_MASK);
    end

    // Purpose: hold the summary bits until read; live banks set them again.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (rd_sum) sum_q <= active_i;
        else             sum_q <= sum_q | active_i;
    end

    // Purpose: hold the summary mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       smask_q <= '1;
        else if (wr_mask) smask_q <= wdata_i;
    end

    // Purpose: register the interrupt request from unmasked summary bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(sum_q & ~smask_q);
    end

    // Purpose: select summary read data, zero-extended.
    always_comb begin
        if (off_i == SUM_OFF_CAUSE)     rdata_o = {{(DW-NB){1'b0}}, sum_q};
        else if (off_i == SUM_OFF_MASK) rdata_o = {{(DW-NB){1'b0}}, smask_q};
        else                            rdata_o = '0;
    end

    assign irq_o = irq_q;

    p_sum_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i != '0) |=> ((sum_q & $past(active_i)) == $past(active_i)));

    p_sum_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sum && (active_i == '0)) |=> (sum_q == '0));

    p_irq_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&smask_q) && $past(rst_n)) |-> !irq_o);

    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(rst_n)) |-> ($past(sum_q) != '0));

endmodule

// File: rtl/irq_cause_unit.sv
// Module irq_cause_unit: top of the aggregated interrupt cause unit. It
// decodes the word address into block and offset, instantiates one
// irqc_bank per cause bank and the summary block, and muxes read data.
// Assumes addr_i[AW-1:OFF_W] selects the block (0..2 banks, 3 summary).
module irq_cause_unit
    import irqc_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 6,
    parameter int HSK_BIT = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev_tx_i,
    input  logic [DW-1:0] ev_rx_i,
    input  logic [DW-1:0] ev_misc_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);

    localparam int            BLK_W   = AW - OFF_W;
    localparam logic [DW-1:0] HSK_ONE = DW'(1) << HSK_BIT;

    logic [BLK_W-1:0] blk;
    logic [OFF_W-1:0] off;
    logic [DW-1:0]    ev_arr   [NBANK];
    logic [DW-1:0]    bank_rd  [NBANK];
    logic [DW-1:0]    bank_msk [NBANK];
    logic [NBANK-1:0] bank_act;
    logic [DW-1:0]    sum_rd;
    logic             sum_sel;

    assign blk       = addr_i[AW-1:OFF_W];
    assign off       = addr_i[OFF_W-1:0];
    assign ev_arr[BANK_TX]   = ev_tx_i;
    assign ev_arr[BANK_RX]   = ev_rx_i;
    assign ev_arr[BANK_MISC] = ev_misc_i;
    assign sum_sel   = (blk == BLK_W'(SUM_BLK));

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        irqc_bank #(.DW(DW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (ev_arr[g]),
            .sel_i    (blk == BLK_W'(g)),
            .wr_en_i  (wr_en_i),
            .rd_en_i  (rd_en_i),
            .off_i    (off),
            .wdata_i  (wdata_i),
            .rdata_o  (bank_rd[g]),
            .mask_o   (bank_msk[g]),
            .active_o (bank_act[g])
        );
    end

    irqc_summary #(.DW(DW), .NB(NBANK)) u_summary (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (bank_act),
        .sel_i    (sum_sel),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .off_i    (off),
        .wdata_i  (wdata_i[NBANK-1:0]),
        .rdata_o  (sum_rd),
        .irq_o    (irq_o)
    );

    // Purpose: route the addressed block's read data to the port.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NBANK; i++)
            if (blk == BLK_W'(i)) rdata_o = bank_rd[i];
        if (sum_sel) rdata_o = sum_rd;
    end

    p_hsk_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((blk == BLK_W'(BANK_MISC)) && wr_en_i && (wdata_i == HSK_ONE) &&
         ((off == OFF_MSET) || (off == OFF_MCLR)))
        |=> ((bank_msk[BANK_MISC] & ~HSK_ONE) == ($past(bank_msk[BANK_MISC]) & ~HSK_ONE)));

endmodule

// File: tb/irq_cause_unit_bench.sv
// Bench for irq_cause_unit: a vector table walked by one loop, then
// directed tests for interrupt timing, collisions and reset.
module irq_cause_unit_bench;

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read and compare, 2 event pulse
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 6'h03, 32'h0, 32'hFFFFFFFF, 4'd1},  // R1 TX mask
        '{2'd1, 6'h0E, 32'h0, 32'h0, 4'd1},         // R1 RX mode
        '{2'd1, 6'h19, 32'h0, 32'h7, 4'd1},         // R1 summary mask
        '{2'd1, 6'h18, 32'h0, 32'h0, 4'd1},         // R1 summary cause
        '{2'd1, 6'h10, 32'h0, 32'h0, 4'd1},         // R1 MISC cause
        '{2'd2, 6'h00, 32'h5, 32'h0, 4'd2},         // R2 TX event
        '{2'd1, 6'h00, 32'h0, 32'h5, 4'd2},
        '{2'd1, 6'h00, 32'h0, 32'h5, 4'd2},         // R2 read in W1C keeps
        '{2'd1, 6'h01, 32'h0, 32'h0, 4'd6},         // R6 masked view
        '{2'd0, 6'h00, 32'h4, 32'h0, 4'd5},
        '{2'd1, 6'h00, 32'h0, 32'h1, 4'd5},         // R5 W1C exact
        '{2'd0, 6'h00, 32'h1, 32'h0, 4'd5},
        '{2'd1, 6'h00, 32'h0, 32'h0, 4'd5},
        '{2'd0, 6'h0A, 32'h30, 32'h0, 4'd3},
        '{2'd1, 6'h08, 32'h0, 32'h30, 4'd3},        // R3 software set
        '{2'd0, 6'h0E, 32'h10, 32'h0, 4'd5},
        '{2'd1, 6'h0E, 32'h0, 32'h10, 4'd5},
        '{2'd0, 6'h08, 32'h30, 32'h0, 4'd5},        // R5 COR bit ignores W1C
        '{2'd1, 6'h08, 32'h0, 32'h10, 4'd5},
        '{2'd1, 6'h08, 32'h0, 32'h0, 4'd6},         // R6 COR cleared by read
        '{2'd0, 6'h0D, 32'hFF, 32'h0, 4'd4},
        '{2'd1, 6'h0B, 32'h0, 32'hFFFFFF00, 4'd4},  // R4 mask clear
        '{2'd0, 6'h0C, 32'h3, 32'h0, 4'd4},
        '{2'd1, 6'h0B, 32'h0, 32'hFFFFFF03, 4'd4},  // R4 mask set
        '{2'd0, 6'h0E, 32'hC04, 32'h0, 4'd6},
        '{2'd0, 6'h0A, 32'hC0C, 32'h0, 4'd6},
        '{2'd1, 6'h09, 32'h0, 32'hC, 4'd6},         // R6 masked read
        '{2'd1, 6'h08, 32'h0, 32'hC08, 4'd6},       // R6 only returned COR cleared
        '{2'd1, 6'h08, 32'h0, 32'h8, 4'd6},
        '{2'd0, 6'h08, 32'h8, 32'h0, 4'd5},
        '{2'd1, 6'h08, 32'h0, 32'h0, 4'd5},
        '{2'd1, 6'h18, 32'h0, 32'h2, 4'd8},         // R8 RX summary sticky
        '{2'd1, 6'h18, 32'h0, 32'h0, 4'd8},         // R8 cleared by read
        '{2'd0, 6'h0C, 32'hFFFFFFFF, 32'h0, 4'd4},
        '{2'd1, 6'h0B, 32'h0, 32'hFFFFFFFF, 4'd4},
        '{2'd0, 6'h15, 32'h0F0F, 32'h0, 4'd10},
        '{2'd1, 6'h13, 32'h0, 32'hFFFFF0F0, 4'd10},
        '{2'd0, 6'h15, 32'h08000000, 32'h0, 4'd10},
        '{2'd1, 6'h13, 32'h0, 32'hF7FFF0F0, 4'd10}, // R10 hand-shake unmask
        '{2'd0, 6'h14, 32'h08000000, 32'h0, 4'd10},
        '{2'd1, 6'h13, 32'h0, 32'hFFFFF0F0, 4'd10}, // R10 hand-shake mask
        '{2'd0, 6'h14, 32'hFFFFFFFF, 32'h0, 4'd4},
        '{2'd0, 6'h19, 32'hFFFFFFF8, 32'h0, 4'd9},
        '{2'd1, 6'h19, 32'h0, 32'h0, 4'd9},         // R9 enable all
        '{2'd0, 6'h19, 32'hFFFFFFFF, 32'h0, 4'd9},
        '{2'd1, 6'h19, 32'h0, 32'h7, 4'd9}          // R9 block all
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ev_tx = '0, ev_rx = '0, ev_misc = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    irq_cause_unit u_irq_cause_unit (
        .clk(clk), .rst_n(rst_n), .ev_tx_i(ev_tx), .ev_rx_i(ev_rx),
        .ev_misc_i(ev_misc), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        #1;
        check(tag, rdata, exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int bank, input logic [31:0] bits);
        if (bank == 0) ev_tx = bits;
        else if (bank == 1) ev_rx = bits;
        else ev_misc = bits;
        @(posedge clk); #1;
        ev_tx = '0; ev_rx = '0; ev_misc = '0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: wr(VEC[i].addr, VEC[i].data);
                2'd1: rd(VEC[i].addr, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
                default: pulse(int'(VEC[i].addr[5:3]), VEC[i].data);
            endcase
        end

        // R9: event to interrupt takes two edges after capture.
        wr(6'h19, 32'hFFFFFFF8);
        wr(6'h05, 32'h1);
        pulse(0, 32'h1);
        check("R9 irq at capture edge", {31'b0, irq}, 32'h0);
        @(posedge clk); #1;
        check("R9 irq one edge later", {31'b0, irq}, 32'h0);
        @(posedge clk); #1;
        check("R9 irq two edges later", {31'b0, irq}, 32'h1);
        wr(6'h19, 32'hFFFFFFFF);
        @(posedge clk); #1;
        check("R9 irq blocked by mask", {31'b0, irq}, 32'h0);
        wr(6'h00, 32'h1);
        rd(6'h18, 32'h1, "R8 TX summary sticky");
        rd(6'h18, 32'h0, "R8 TX summary cleared");

        // R7: event against a W1C write on the same bit.
        wr_en = 1'b1; addr = 6'h00; wdata = 32'h1; ev_tx = 32'h1;
        @(posedge clk); #1;
        wr_en = 1'b0; ev_tx = '0;
        rd(6'h00, 32'h1, "R7 event beats W1C");
        wr(6'h00, 32'h1);
        rd(6'h00, 32'h0, "R5 cleared after collision");

        // R7: event against a clear-on-read read on the same bit.
        wr(6'h06, 32'h2);
        pulse(0, 32'h2);
        rd_en = 1'b1; addr = 6'h00; ev_tx = 32'h2;
        #1 check("R6 COR read value", rdata, 32'h2);
        @(posedge clk); #1;
        rd_en = 1'b0; ev_tx = '0;
        rd(6'h00, 32'h2, "R7 event beats COR");
        rd(6'h00, 32'h0, "R6 COR cleared");

        // R1: reset mid-run restores defaults.
        wr(6'h0A, 32'hFF);
        wr(6'h0D, 32'hFF);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        rd(6'h08, 32'h0, "R1 cause after reset");
        rd(6'h0B, 32'hFFFFFFFF, "R1 mask after reset");
        rd(6'h06, 32'h0, "R1 mode after reset");
        check("R1 irq low after reset", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule